// File: doc/BRIEF.md
# Shadow Memory Transfer Engine

This block pairs a volatile byte array with a nonvolatile shadow array of the same size and moves the whole contents between them on command. A host byte port with active-low enable, write and output-enable controls reads and writes the volatile array during normal operation. A store strobe copies the volatile array into the shadow. The copy runs in two phases: the shadow is first erased to a fixed erase value, then programmed one byte per cycle. A recall strobe runs the other way. The volatile array is first cleared to a fixed clear value, then loaded from the shadow. A recall never writes the shadow.

Each operation keeps the block busy for a programmable number of clock cycles, which stand for the physical store and recall times. The host port is shut off for that whole window. A one-cycle done pulse marks the return to normal access. The array depth is set by the address width. The full configuration uses 13 address bits, giving 8192 bytes in each array. The default address width is smaller so that elaboration stays light.

Top module: `snv_shadow_sram`

## Requirements
- R1: Each array holds 2**ADDR_W bytes (8192 with ADDR_W=13). While idle, en_n=0 with wr_n=0 writes din into the volatile byte at addr on the clock edge.
- R2: While idle, en_n=0, oe_n=0 and wr_n=1 perform a read, and in the next cycle rd_valid=1 with rd_data equal to the addressed byte. Any other control combination gives rd_valid=0 in the next cycle.
- R3: A store first writes ERASE_VAL to every shadow byte in ascending address order, then copies every volatile byte into the shadow. A later recall then returns the volatile contents captured by the store.
- R4: A recall first writes CLEAR_VAL to every volatile byte, then loads every volatile byte from the shadow. Afterwards each volatile byte equals the shadow byte at the same address.
- R5: A recall leaves the shadow unchanged, so repeated recalls with host writes between them always restore the same stored contents.
- R6: busy rises in the cycle after an accepted strobe and stays high for exactly STORE_CYC cycles for a store and RECALL_CYC cycles for a recall. Both values must be at least 2**(ADDR_W+1).
- R7: done is high for exactly one cycle, the first cycle in which busy is low again after an operation.
- R8: While busy, host reads give rd_valid=0 and host writes leave the volatile array unchanged.
- R9: A store or recall strobe that arrives while busy is ignored. The running operation keeps its length, and no second operation follows it.
- R10: If both strobes arrive in the same idle cycle, the store is performed and the recall is dropped.
- R11: During and right after reset, busy, done and rd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Host byte address |
| din | input | DATA_W | Host write data |
| en_n | input | 1 | Host access enable, active low |
| wr_n | input | 1 | Write select, active low |
| oe_n | input | 1 | Output enable, active low |
| store_go | input | 1 | Start a volatile-to-shadow store |
| recall_go | input | 1 | Start a shadow-to-volatile recall |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | rd_data holds a fresh read; low models a high-impedance bus |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench writes to the volatile array in the middle of a store. A design that let that write through would read back the injected byte afterwards instead of the original value. It also raises a recall strobe inside a running store. A design that queued or restarted on that strobe would stretch busy past STORE_CYC or emit a second done. Both strobes are raised together after the volatile array has been changed. A design that let the recall win would restore old shadow data instead of capturing the new values. Two recalls in a row, with overwrites before each, show whether a recall disturbs the shadow, since a broken design would restore cleared or changed data.

// File: rtl/snv_pkg.sv
package snv_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ERASE = 3'd1,
      PH_PROG  = 3'd2,
      PH_CLEAR = 3'd3,
      PH_LOAD  = 3'd4,
      PH_HOLD  = 3'd5
   } phase_t;

   function automatic logic phase_is_store(input phase_t p);
      return (p == PH_ERASE) || (p == PH_PROG);
   endfunction

   function automatic logic phase_is_recall(input phase_t p);
      return (p == PH_CLEAR) || (p == PH_LOAD);
   endfunction

endpackage

// File: rtl/snv_bank.sv
module snv_bank #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/snv_engine.sv
module snv_engine
   import snv_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int STORE_CYC  = 2100,
   parameter int RECALL_CYC = 2060
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_go,
   input  logic              recall_go,
   output phase_t            phase,
   output logic [ADDR_W-1:0] idx,
   output logic              busy,
   output logic              done,
   output logic              vol_we,
   output logic              vol_from_shadow,
   output logic              shd_we,
   output logic              shd_from_vol
);
   localparam int DEPTH   = 1 << ADDR_W;
   localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [ADDR_W-1:0] LAST_IDX  = ADDR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0]  ST_RELOAD = CNT_W'(STORE_CYC - 1);
   localparam logic [CNT_W-1:0]  RC_RELOAD = CNT_W'(RECALL_CYC - 1);

   generate
      if (STORE_CYC < 2 * DEPTH) begin : g_bad_store
         $error("snv_engine: STORE_CYC must cover erase and program phases");
      end
      if (RECALL_CYC < 2 * DEPTH) begin : g_bad_recall
         $error("snv_engine: RECALL_CYC must cover clear and load phases");
      end
   endgenerate

   logic [CNT_W-1:0] remain;
   logic             idx_last;

   assign idx_last = (idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         idx    <= '0;
         remain <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (phase == PH_IDLE) begin
            idx <= '0;
            if (store_go) begin
               phase  <= PH_ERASE;
               remain <= ST_RELOAD;
            end else if (recall_go) begin
               phase  <= PH_CLEAR;
               remain <= RC_RELOAD;
            end
         end else begin
            remain <= remain - 1'b1;
            idx    <= idx + 1'b1;
            if (remain == '0) begin
               phase <= PH_IDLE;
               done  <= 1'b1;
            end else begin
               unique case (phase)
                  PH_ERASE: if (idx_last) phase <= PH_PROG;
                  PH_PROG:  if (idx_last) phase <= PH_HOLD;
                  PH_CLEAR: if (idx_last) phase <= PH_LOAD;
                  PH_LOAD:  if (idx_last) phase <= PH_HOLD;
                  default:  phase <= phase;
               endcase
            end
         end
      end
   end

   assign busy            = (phase != PH_IDLE);
   assign vol_we          = phase_is_recall(phase);
   assign vol_from_shadow = (phase == PH_LOAD);
   assign shd_we          = phase_is_store(phase);
   assign shd_from_vol    = (phase == PH_PROG);

endmodule

// File: rtl/snv_host.sv
module snv_host #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 8,
   parameter bit HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              en_n,
   input  logic              wr_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              host_we,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic rd_fire;

   assign host_we = !busy && !en_n && !wr_n;
   assign rd_fire = !busy && !en_n && !oe_n && wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_fire;
   end

   generate
      if (HOLD_RDATA) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       rd_data <= '0;
            else if (rd_fire) rd_data <= mem_rdata;
         end
      end else begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= rd_fire ? mem_rdata : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/snv_shadow_sram.sv
module snv_shadow_sram
   import snv_pkg::*;
#(
   parameter int              ADDR_W     = 10,
   parameter int              DATA_W     = 8,
   parameter int              STORE_CYC  = 2100,
   parameter int              RECALL_CYC = 2060,
   parameter logic [DATA_W-1:0] ERASE_VAL = '1,
   parameter logic [DATA_W-1:0] CLEAR_VAL = '0,
   parameter bit              HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              en_n,
   input  logic              wr_n,
   input  logic              oe_n,
   input  logic              store_go,
   input  logic              recall_go,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              done
);
   localparam int N_BANK = 2;
   localparam int VOL    = 0;
   localparam int SHD    = 1;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("snv_shadow_sram: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   phase_t            eng_phase;
   logic [ADDR_W-1:0] eng_idx;
   logic              eng_vol_we, eng_vol_src, eng_shd_we, eng_shd_src;
   logic              host_we;

   logic              bank_we    [N_BANK];
   logic [ADDR_W-1:0] bank_waddr [N_BANK];
   logic [DATA_W-1:0] bank_wdata [N_BANK];
   logic [ADDR_W-1:0] bank_raddr [N_BANK];
   logic [DATA_W-1:0] bank_rdata [N_BANK];

   snv_engine #(
      .ADDR_W     (ADDR_W),
      .STORE_CYC  (STORE_CYC),
      .RECALL_CYC (RECALL_CYC)
   ) u_engine (
      .clk             (clk),
      .rst_n           (rst_n),
      .store_go        (store_go),
      .recall_go       (recall_go),
      .phase           (eng_phase),
      .idx             (eng_idx),
      .busy            (busy),
      .done            (done),
      .vol_we          (eng_vol_we),
      .vol_from_shadow (eng_vol_src),
      .shd_we          (eng_shd_we),
      .shd_from_vol    (eng_shd_src)
   );

   snv_host #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .HOLD_RDATA (HOLD_RDATA)
   ) u_host (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .en_n      (en_n),
      .wr_n      (wr_n),
      .oe_n      (oe_n),
      .mem_rdata (bank_rdata[VOL]),
      .host_we   (host_we),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

   generate
      for (genvar b = 0; b < N_BANK; b++) begin : g_bank
         if (b == VOL) begin : g_vol
            always_comb begin
               bank_we[b]    = host_we || eng_vol_we;
               bank_waddr[b] = busy ? eng_idx : addr;
               bank_raddr[b] = busy ? eng_idx : addr;
               if (eng_vol_we) bank_wdata[b] = eng_vol_src ? bank_rdata[SHD] : CLEAR_VAL;
               else            bank_wdata[b] = din;
            end
         end else begin : g_shd
            always_comb begin
               bank_we[b]    = eng_shd_we;
               bank_waddr[b] = eng_idx;
               bank_raddr[b] = eng_idx;
               bank_wdata[b] = eng_shd_src ? bank_rdata[VOL] : ERASE_VAL;
            end
         end

         snv_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
         ) u_bank (
            .clk   (clk),
            .we    (bank_we[b]),
            .waddr (bank_waddr[b]),
            .wdata (bank_wdata[b]),
            .raddr (bank_raddr[b]),
            .rdata (bank_rdata[b])
         );
      end
   endgenerate

endmodule

// File: rtl/snv_shadow_chk.sv
module snv_shadow_chk
   import snv_pkg::*;
#(
   parameter int STORE_CYC  = 2100,
   parameter int RECALL_CYC = 2060
) (
   input logic   clk,
   input logic   rst_n,
   input logic   store_go,
   input logic   recall_go,
   input logic   en_n,
   input logic   wr_n,
   input logic   oe_n,
   input logic   busy,
   input logic   done,
   input logic   rd_valid,
   input phase_t phase
);
   int   run_len;
   logic run_store;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len   <= 0;
         run_store <= 1'b0;
      end else begin
         run_len <= busy ? run_len + 1 : 0;
         if (!busy && store_go)       run_store <= 1'b1;
         else if (!busy && recall_go) run_store <= 1'b0;
      end
   end

   p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_len == (run_store ? STORE_CYC : RECALL_CYC));

   p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (store_go || recall_go)) |=> busy);

   p_done_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !en_n && !oe_n && wr_n) |=> rd_valid);

   p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rd_valid);

   p_prog_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PROG) |-> ($past(phase) == PH_ERASE || $past(phase) == PH_PROG));

   p_load_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOAD) |-> ($past(phase) == PH_CLEAR || $past(phase) == PH_LOAD));

   p_store_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && store_go && recall_go) |=> phase == PH_ERASE);

   p_no_recall_in_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CLEAR) |-> $past(phase) == PH_IDLE || $past(phase) == PH_CLEAR);

endmodule

bind snv_shadow_sram snv_shadow_chk #(
   .STORE_CYC  (STORE_CYC),
   .RECALL_CYC (RECALL_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .store_go  (store_go),
   .recall_go (recall_go),
   .en_n      (en_n),
   .wr_n      (wr_n),
   .oe_n      (oe_n),
   .busy      (busy),
   .done      (done),
   .rd_valid  (rd_valid),
   .phase     (eng_phase)
);

// File: tb/snv_shadow_sram_bench.sv
`timescale 1ns/1ps
module snv_shadow_sram_bench;
   localparam int AW   = 6;
   localparam int DW   = 8;
   localparam int ST_C = 150;
   localparam int RC_C = 140;
   localparam int NV   = 12;

   localparam logic [AW+DW-1:0] VEC [NV] = '{
      {6'h00, 8'h3C}, {6'h3F, 8'hC3}, {6'h01, 8'hA5}, {6'h15, 8'h5A},
      {6'h2A, 8'h0F}, {6'h10, 8'hF0}, {6'h20, 8'h81}, {6'h07, 8'h7E},
      {6'h38, 8'h00}, {6'h0C, 8'hFF}, {6'h33, 8'h96}, {6'h1E, 8'h69}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic          en_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
   logic          store_go = 1'b0, recall_go = 1'b0;
   logic [DW-1:0] rd_data;
   logic          rd_valid, busy, done;

   int n_chk = 0;
   int n_bad = 0;
   int busy_seen = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   snv_shadow_sram #(
      .ADDR_W (AW), .DATA_W (DW), .STORE_CYC (ST_C), .RECALL_CYC (RC_C)
   ) u_snv_shadow_sram (
      .clk (clk), .rst_n (rst_n), .addr (addr), .din (din),
      .en_n (en_n), .wr_n (wr_n), .oe_n (oe_n),
      .store_go (store_go), .recall_go (recall_go),
      .rd_data (rd_data), .rd_valid (rd_valid), .busy (busy), .done (done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (busy) busy_seen++;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr = a; din = d; en_n = 1'b0; wr_n = 1'b0;
      tick();
      en_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
      addr = a; en_n = 1'b0; oe_n = 1'b0; wr_n = 1'b1;
      tick();
      check(req, rd_valid, 1'b1);
      check(req, rd_data, exp);
      en_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic kick(input logic st, input logic rc);
      busy_seen = 0;
      store_go = st; recall_go = rc;
      tick();
      store_go = 1'b0; recall_go = 1'b0;
   endtask

   task automatic finish_op(input int exp_len, input string req);
      while (busy && busy_seen < 4 * ST_C) tick();
      check(req, busy_seen, exp_len);
      check("R7 done at end", done, 1'b1);
      tick();
      check("R7 done one cycle", done, 1'b0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
   end

   initial begin
      tick(); tick();
      // R11: reset values
      check("R11 busy in reset", busy, 1'b0);
      check("R11 done in reset", done, 1'b0);
      check("R11 rd_valid in reset", rd_valid, 1'b0);
      rst_n = 1'b1;
      tick();
      check("R11 busy after reset", busy, 1'b0);

      // R1 R2: table walk, write then read back
      for (int i = 0; i < NV; i++) wr(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
      for (int i = 0; i < NV; i++) rd(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], "R1 R2 readback");

      // R2: oe_n high gives no read
      addr = VEC[0][AW+DW-1:DW]; en_n = 1'b0; oe_n = 1'b1; wr_n = 1'b1;
      tick();
      check("R2 no read with oe_n high", rd_valid, 1'b0);
      en_n = 1'b1;

      // R3 R6 R8 R9: store with blocked access and stray recall strobe
      kick(1'b1, 1'b0);
      check("R6 busy after store strobe", busy, 1'b1);
      tick(); tick();
      wr(VEC[0][AW+DW-1:DW], 8'hEE);
      addr = VEC[1][AW+DW-1:DW]; en_n = 1'b0; oe_n = 1'b0; wr_n = 1'b1;
      tick();
      check("R8 rd_valid low while busy", rd_valid, 1'b0);
      en_n = 1'b1; oe_n = 1'b1;
      recall_go = 1'b1;
      tick();
      recall_go = 1'b0;
      finish_op(ST_C, "R6 R9 store length");
      tick(); tick();
      check("R9 no second operation", busy, 1'b0);
      rd(VEC[0][AW+DW-1:DW], VEC[0][DW-1:0], "R8 write ignored while busy");

      // R4 R3: overwrite, recall restores stored data
      for (int i = 0; i < NV; i++) wr(VEC[i][AW+DW-1:DW], ~VEC[i][DW-1:0]);
      rd(VEC[2][AW+DW-1:DW], ~VEC[2][DW-1:0], "R1 overwrite");
      kick(1'b0, 1'b1);
      finish_op(RC_C, "R6 recall length");
      for (int i = 0; i < NV; i++) rd(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], "R3 R4 recall data");

      // R5: shadow unchanged by recall, second recall
      for (int i = 0; i < NV; i++) wr(VEC[i][AW+DW-1:DW], 8'h11 ^ VEC[i][DW-1:0]);
      kick(1'b0, 1'b1);
      finish_op(RC_C, "R5 second recall length");
      for (int i = 0; i < NV; i++) rd(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], "R5 repeated recall");

      // R10: both strobes, store wins
      for (int i = 0; i < NV; i++) wr(VEC[i][AW+DW-1:DW], ~VEC[i][DW-1:0]);
      kick(1'b1, 1'b1);
      finish_op(ST_C, "R10 store length with both strobes");
      rd(VEC[3][AW+DW-1:DW], ~VEC[3][DW-1:0], "R10 volatile untouched");
      for (int i = 0; i < NV; i++) wr(VEC[i][AW+DW-1:DW], 8'h00);
      kick(1'b0, 1'b1);
      finish_op(RC_C, "R10 recall after store");
      for (int i = 0; i < NV; i++) rd(VEC[i][AW+DW-1:DW], ~VEC[i][DW-1:0], "R10 store captured new data");

      summary();
   end

endmodule